// File: doc/BRIEF.md
# Streaming Additive Scrambler with Serial and Byte Lanes

This block whitens a data stream for a wireless physical-layer path. It keeps a 7-bit pseudo-random shift register and XORs the bits it produces onto the payload. XOR with the same sequence undoes itself, so one instance on the transmit side scrambles and a second instance on the receive side restores the original data. Both instances must be reseeded at the same packet boundary.

A static width input picks one of two lanes. In serial mode each beat carries one bit. In byte mode each beat carries eight bits, and the block advances the register eight positions in a single cycle. The byte lane is an unrolled copy of the serial step, so a byte stream and the same bits fed one at a time give identical output. A one-cycle start-of-packet pulse reloads the all-ones seed.

Data moves over valid/ready handshakes on both sides. A beat is taken when `in_valid` and `in_ready` are both high at a clock edge. The result sits in a single output register until the consumer takes it with `out_ready`. While that register is full and not being drained, `in_ready` is low, so back-pressure reaches the producer in the same cycle. A stalled output never loses or duplicates a beat.

Top module: `scrambler_stream`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and the register holds the all-ones seed. The first beat without a start pulse is therefore scrambled from that seed.
- R2: A single bit step works as follows. The feedback is register bit 3 XOR register bit 0. Bits 6..1 shift into positions 5..0, and the feedback enters bit 6. The output bit is the input bit XOR the feedback.
- R3: With `mode_byte` = 0, one step is made per beat. Only `in_data[0]` is used, and the result appears on `out_data[0]`. `out_data[7:1]` is 0, and `in_data[7:1]` has no effect.
- R4: With `mode_byte` = 1, one beat makes eight steps. `in_data[0]` is processed first and its result goes to `out_data[0]`. `in_data[7]` is processed last and its result goes to `out_data[7]`.
- R5: A byte stream and the same bits fed serially, least significant bit first, produce identical output bits.
- R6: A `sop` pulse with no accepted beat reloads the seed. It produces no output.
- R7: A `sop` pulse in the same cycle as an accepted beat reloads the seed first, and that beat is scrambled from the fresh seed.
- R8: The handshake follows these rules. `in_ready` = !`out_valid` | `out_ready`. An accepted beat shows on `out_valid`/`out_data` after the next edge. A taken output with no new beat clears `out_valid`.
- R9: While `out_valid` = 1 and `out_ready` = 0, `out_data`, `out_valid` and the register state hold, and `in_ready` stays 0.
- R10: The register advances only on accepted beats. Idle cycles leave the sequence where it was.
- R11: A second instance fed with the first instance's output, and reseeded at the same packet start, returns the original data.
- R12: `mode_byte` may change between packets. The next packet, opened with `sop`, follows the new width from the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_byte | input | 1 | 1: eight bits per beat, 0: one bit per beat (static within a packet) |
| sop | input | 1 | Start-of-packet pulse, reloads the seed |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | 8 | Input bits, bit 0 first |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the output |
| out_data | output | 8 | Scrambled bits |

## Verification
Each accepted beat produces its result one edge later. The bench therefore samples `out_valid` and `out_data` one time unit after the accepting edge and compares them against a bit-level model. That model advances only when the bench knows a beat was accepted. During a stall, the held output and `in_ready` are checked on every stalled cycle. The pending beat is checked on the first edge after `out_ready` returns. The descrambling instance adds one more register, so its output is compared two edges after the original beat. The comparison uses an index into the log of accepted beats, not a cycle count.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned LFSR_W = 7;
  localparam int unsigned TAP_A  = 3;
  localparam int unsigned TAP_B  = 0;
  typedef logic [LFSR_W-1:0] lfsr_t;
  localparam lfsr_t SEED = '1;
endpackage

// File: rtl/scr_bit_step.sv
module scr_bit_step
  import scr_pkg::*;
(
  input  lfsr_t cur,
  input  logic  din,
  output lfsr_t nxt,
  output logic  dout
);
  logic fb;
  assign fb   = cur[TAP_A] ^ cur[TAP_B];
  assign nxt  = {fb, cur[LFSR_W-1:1]};
  assign dout = din ^ fb;
endmodule

// File: rtl/scr_unroll.sv
module scr_unroll
  import scr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  lfsr_t             start,
  input  logic [DATA_W-1:0] din,
  output lfsr_t             after_one,
  output lfsr_t             after_all,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W:0][LFSR_W-1:0] chain;

  assign chain[0] = start;

  for (genvar g = 0; g < DATA_W; g++) begin : g_step
    scr_bit_step u_step (
      .cur  (chain[g]),
      .din  (din[g]),
      .nxt  (chain[g+1]),
      .dout (dout[g])
    );
  end

  assign after_one = chain[1];
  assign after_all = chain[DATA_W];
endmodule

// File: rtl/scr_state_reg.sv
module scr_state_reg
  import scr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  reload,
  input  logic  advance,
  input  lfsr_t nxt,
  output lfsr_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       q <= SEED;
    else if (advance) q <= nxt;
    else if (reload)  q <= SEED;
  end
endmodule

// File: rtl/scr_out_stage.sv
module scr_out_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              can_take
);
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/scrambler_stream.sv
module scrambler_stream
  import scr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_byte,
  input  logic              sop,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int unsigned PAD_W = DATA_W - 1;

  lfsr_t             st_q;
  lfsr_t             start_st;
  lfsr_t             st_one;
  lfsr_t             st_all;
  lfsr_t             st_next;
  logic [DATA_W-1:0] scr_all;
  logic [DATA_W-1:0] scr_word;
  logic              accept;

  assign accept   = in_valid && in_ready;
  assign start_st = sop ? SEED : st_q;

  scr_unroll #(.DATA_W(DATA_W)) u_unroll (
    .start     (start_st),
    .din       (in_data),
    .after_one (st_one),
    .after_all (st_all),
    .dout      (scr_all)
  );

  assign st_next  = mode_byte ? st_all : st_one;
  assign scr_word = mode_byte ? scr_all : {{PAD_W{1'b0}}, scr_all[0]};

  scr_state_reg u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (sop),
    .advance (accept),
    .nxt     (st_next),
    .q       (st_q)
  );

  scr_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .d         (scr_word),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .can_take  (in_ready)
  );
endmodule

// File: rtl/scrambler_stream_checker.sv
module scrambler_stream_checker
  import scr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_byte,
  input logic              sop,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input lfsr_t             state
);
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_accept_shows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !(in_valid && in_ready) |=> !out_valid);

  assert_state_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) && !sop |=> $stable(state));

  assert_sop_reseed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sop && !(in_valid && in_ready) |=> state == SEED);

  assert_serial_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !mode_byte |-> out_data[DATA_W-1:1] == '0);
endmodule

bind scrambler_stream scrambler_stream_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_byte (mode_byte),
  .sop       (sop),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .state     (st_q)
);

// File: tb/test_scrambler_stream.sv
module test_scrambler_stream;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_byte = 1'b1;
  logic         sop = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         tb_out_ready = 1'b1;
  logic         in_ready, out_valid;
  logic [W-1:0] out_data;

  logic         rx_in_ready, rx_out_valid, rx_sop_pend;
  logic [W-1:0] rx_out_data;
  logic         rx_in_valid, rx_sop;

  int checks = 0;
  int errors = 0;
  int tx_n = 0;
  int rx_n = 0;
  int cyc = 0;
  logic [6:0] ref_st = 7'h7f;
  logic [W-1:0] tx_mem [0:4095];
  logic [W-1:0] byt_out [0:15];
  logic [W-1:0] ser_out [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rx_in_valid = out_valid && tb_out_ready;
  assign rx_sop      = rx_sop_pend && rx_in_valid;

  scrambler_stream #(.DATA_W(W)) i_scrambler_stream (
    .clk(clk), .rst_n(rst_n), .mode_byte(mode_byte), .sop(sop),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(tb_out_ready), .out_data(out_data)
  );

  scrambler_stream #(.DATA_W(W)) i_scrambler_stream_rx (
    .clk(clk), .rst_n(rst_n), .mode_byte(mode_byte), .sop(rx_sop),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(out_data),
    .out_valid(rx_out_valid), .out_ready(1'b1), .out_data(rx_out_data)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // log accepted beats for the descrambling comparison
  always @(posedge clk) begin
    if (!rst_n) rx_sop_pend <= 1'b0;
    else if (sop) rx_sop_pend <= 1'b1;
    else if (rx_in_valid) rx_sop_pend <= 1'b0;
    if (rst_n && in_valid && in_ready) begin
      tx_mem[tx_n] = mode_byte ? in_data : {{(W-1){1'b0}}, in_data[0]};
      tx_n = tx_n + 1;
    end
  end

  // R11: descrambled output equals the original beats
  always @(negedge clk) begin
    if (rst_n && rx_out_valid) begin
      chk("R11 descramble", rx_out_data, tx_mem[rx_n]);
      rx_n++;
    end
  end

  task automatic model(input logic bm, input logic [W-1:0] d, output logic [W-1:0] o);
    logic fb;
    o = '0;
    for (int i = 0; i < (bm ? W : 1); i++) begin
      fb = ref_st[3] ^ ref_st[0];
      ref_st = {fb, ref_st[6:1]};
      o[i] = d[i] ^ fb;
    end
  endtask

  task automatic beat(input logic s, input logic [W-1:0] d, input string tag,
                      output logic [W-1:0] got);
    logic [W-1:0] exp;
    @(negedge clk);
    sop = s; in_valid = 1'b1; in_data = d;
    if (s) ref_st = 7'h7f;
    model(mode_byte, d, exp);
    @(posedge clk); #1;
    sop = 1'b0; in_valid = 1'b0;
    chk(tag, {7'b0, out_valid}, 8'h01);
    chk(tag, out_data, exp);
    got = out_data;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] g, held, exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 out_valid after reset", {7'b0, out_valid}, 8'h00);
    chk("R1 in_ready after reset", {7'b0, in_ready}, 8'h01);

    // R1 seed, R4 byte sweep over every byte value
    beat(1'b0, 8'h00, "R1 first beat from seed", g);
    for (int k = 1; k < 256; k++) beat(1'b0, k[7:0], "R4 byte sweep", g);

    // R8 drain, R10 idle keeps the sequence
    repeat (3) @(negedge clk);
    chk("R8 drained", {7'b0, out_valid}, 8'h00);
    beat(1'b0, 8'ha7, "R10 continues after idle", g);

    // R6 sop alone
    @(negedge clk); sop = 1'b1;
    @(posedge clk); #1; sop = 1'b0;
    ref_st = 7'h7f;
    @(negedge clk);
    chk("R6 no output from bare sop", {7'b0, out_valid}, 8'h00);
    beat(1'b0, 8'h5a, "R6 reseeded", g);
    beat(1'b0, 8'h11, "R6 second beat", g);

    // R7 sop with a beat
    beat(1'b1, 8'hc4, "R7 sop with beat", g);
    beat(1'b0, 8'h3b, "R7 follow", g);

    // R5 byte reference packet
    repeat (3) @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      beat(k == 0, 8'(k * 37 + 11), "R5 byte packet", g);
      byt_out[k] = g;
    end
    repeat (3) @(negedge clk);
    mode_byte = 1'b0;
    // R12 new width, R3 upper input bits ignored
    for (int k = 0; k < 16; k++) begin
      logic [W-1:0] d;
      d = 8'(k * 37 + 11);
      ser_out[k] = '0;
      for (int b = 0; b < W; b++) begin
        beat(k == 0 && b == 0, {7'(8'h55 ^ 8'(k * 3 + b)), d[b]},
             (k == 0 && b == 0) ? "R12 serial after switch" : "R3 serial", g);
        ser_out[k][b] = g[0];
      end
    end
    for (int k = 0; k < 16; k++) chk("R5 serial equals byte", ser_out[k], byt_out[k]);

    // R2 raw sequence on zero input, period check
    beat(1'b1, 8'h00, "R2 serial zeros", g);
    for (int i = 1; i < 254; i++) beat(1'b0, 8'h00, "R2 serial zeros", g);

    // R9 stall in byte mode
    repeat (3) @(negedge clk);
    mode_byte = 1'b1;
    beat(1'b1, 8'h3c, "R9 before stall", held);
    @(negedge clk);
    tb_out_ready = 1'b0; in_valid = 1'b1; in_data = 8'hc3;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk("R9 held valid", {7'b0, out_valid}, 8'h01);
      chk("R9 held data", out_data, held);
      chk("R9 in_ready low", {7'b0, in_ready}, 8'h00);
    end
    @(negedge clk);
    tb_out_ready = 1'b1;
    model(1'b1, 8'hc3, exp);
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk("R9 data after release", out_data, exp);
    beat(1'b0, 8'h96, "R9 continues", g);

    repeat (5) @(negedge clk);
    chk("R11 all beats returned", 8'(rx_n), 8'(tx_n));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule